// File: doc/BRIEF.md
# Periodic Wake-Up Polling Timer

This block produces the sleep and wake schedule for a duty-cycled receiver. It runs a repeating cycle that has an awake window and a sleep window. Two configuration inputs set the lengths of those windows in microsecond ticks. An active-low interrupt line tells external logic when to act. A clock-output enable tells the board-level clock driver when its clock is wanted. All timing comes from two input strobes: a 1 µs timebase tick and a tick once per data-rate period.

A two-bit mode input selects where the interrupt is placed. In timer mode the interrupt marks the end of every full awake-plus-sleep cycle. In polling mode it fires once in each awake window, after the receiver has had time to settle. That settling time is a fixed 2.6 ms followed by three data-rate periods. In continuous mode the interrupt follows each data-valid decision strobe from the detector. One configuration bit chooses between a clock output that is always on and one that is gated by the polling schedule.

Top module: `wake_poll_timer`

## Requirements
- R1: After reset, `irq_n` is high, `on_window` is high, and `clkout_en` is high. The first awake window starts straight out of reset.
- R2: Every interrupt pulse holds `irq_n` low for exactly PULSE_US (default 15) consumed `us_tick` strobes.
- R3: With `mode` = 0 (timer), `on_window` stays high for `on_time` ticks and then low for `off_time` ticks. `irq_n` falls once at the end of each full cycle, so successive falls are `on_time + off_time` ticks apart.
- R4: With `mode` = 1 (polling), `irq_n` falls after SETTLE_US (default 2600) `us_tick` strobes, counted from the start of the awake window, followed by RATE_PERIODS (default 3) `rate_tick` strobes. Rate strobes that arrive before the microsecond part has finished do not count.
- R5: With `mode` = 1, no pulse is issued in a cycle whose awake window ends before the settling delay completes. The settling count restarts at every awake window.
- R6: With `mode` = 2 (continuous), a high `dv_strobe` sampled on a clock edge starts a pulse at that edge. In modes 0, 1 and 3, `dv_strobe` has no effect. Mode 3 issues no pulses.
- R7: A pulse request that arrives while a pulse is already active is ignored. The active pulse is neither extended nor restarted.
- R8: With `mode` = 1 and `clk_always_on` = 0, `clkout_en` is high only while `on_window` is high and `irq_n` is high. It is low during the sleep window and during a pulse.
- R9: With `clk_always_on` = 1, `clkout_en` is high at all times. With `clk_always_on` = 0 in modes 0, 2 and 3, `clkout_en` is also high at all times.
- R10: A new `on_time` or `off_time` value written during a cycle does not change that cycle. It takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-clock strobe every microsecond |
| rate_tick | input | 1 | One-clock strobe every data-rate period |
| mode | input | 2 | 0 timer, 1 polling, 2 continuous, 3 silent |
| clk_always_on | input | 1 | 1 keeps the clock output enabled permanently |
| on_time | input | TIME_W | Awake window length in µs ticks |
| off_time | input | TIME_W | Sleep window length in µs ticks |
| dv_strobe | input | 1 | Data-valid decision strobe from the detector |
| irq_n | output | 1 | Active-low interrupt pulse, idles high |
| clkout_en | output | 1 | Enable for the external clock output |
| on_window | output | 1 | High during the awake window |

## Verification
The hardest case to reach from the ports is the rule that rate-period strobes only count once the 2.6 ms microsecond stage has finished. This case is hard because a free-running rate strobe hides it. The stimulus therefore keeps `rate_tick` under direct control in one polling test. It gives three rate strobes early in the awake window and checks that `irq_n` is still high well past 2.6 ms. It then gives the strobes one by one and checks that the pulse starts only after the third. A second hard case is an awake window shorter than the settling delay. A short-window run spans several full cycles and checks that no pulse ever appears while the window keeps toggling.

// File: rtl/wkt_pkg.sv
// Package: shared types for the wake-up polling timer.
// Assumes: mode encodings are fixed and decoded the same way by the checker.
package wkt_pkg;

    // Interrupt placement modes
    typedef enum logic [1:0] {
        MODE_TIMER = 2'd0,
        MODE_POLL  = 2'd1,
        MODE_CONT  = 2'd2,
        MODE_QUIET = 2'd3
    } wkt_mode_e;

    // Cycle phases: a one-clock load step, then awake, then sleep
    typedef enum logic [1:0] {
        PH_LOAD = 2'd0,
        PH_ON   = 2'd1,
        PH_OFF  = 2'd2
    } wkt_phase_e;

    // Settling sequencer stages
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_US   = 2'd1,
        ST_RATE = 2'd2
    } wkt_settle_e;

endpackage

// File: rtl/wkt_cycle_timer.sv
// Module: wkt_cycle_timer
// Runs the repeating awake/sleep cycle. The window lengths are captured in a
// one-clock load step at the start of each cycle, so a value written mid-cycle
// applies from the next cycle. A zero length is treated as one tick.
// Assumes: us_tick is a single-clock strobe and never high on two
// consecutive clocks.
module wkt_cycle_timer
    import wkt_pkg::*;
#(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic [TIME_W-1:0] on_time,
    input  logic [TIME_W-1:0] off_time,
    output logic              on_phase,
    output logic              cycle_start,
    output logic              cycle_end
);

    localparam int LEN_W = TIME_W + 1;

    wkt_phase_e        phase_q;
    logic [TIME_W-1:0] cnt_q;
    logic [TIME_W-1:0] on_lat_q;
    logic [TIME_W-1:0] off_lat_q;
    logic              start_q;
    logic              end_q;
    logic [LEN_W-1:0]  on_len;
    logic [LEN_W-1:0]  off_len;
    logic [LEN_W-1:0]  cnt_next;
    logic              on_done;
    logic              off_done;

    // Effective window lengths, never shorter than one tick
    always_comb begin
        on_len   = (on_lat_q  == '0) ? LEN_W'(1) : {1'b0, on_lat_q};
        off_len  = (off_lat_q == '0) ? LEN_W'(1) : {1'b0, off_lat_q};
        cnt_next = {1'b0, cnt_q} + LEN_W'(1);
        on_done  = us_tick && (cnt_next >= on_len);
        off_done = us_tick && (cnt_next >= off_len);
    end

    // Phase sequencing, tick counting and length capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_LOAD;
            cnt_q     <= '0;
            on_lat_q  <= '0;
            off_lat_q <= '0;
            start_q   <= 1'b0;
            end_q     <= 1'b0;
        end else begin
            start_q <= 1'b0;
            end_q   <= 1'b0;
            case (phase_q)
                PH_LOAD: begin
                    on_lat_q  <= on_time;
                    off_lat_q <= off_time;
                    cnt_q     <= '0;
                    phase_q   <= PH_ON;
                    start_q   <= 1'b1;
                end
                PH_ON: begin
                    if (on_done) begin
                        cnt_q   <= '0;
                        phase_q <= PH_OFF;
                    end else if (us_tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_OFF: begin
                    if (off_done) begin
                        cnt_q   <= '0;
                        phase_q <= PH_LOAD;
                        end_q   <= 1'b1;
                    end else if (us_tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_LOAD;
            endcase
        end
    end

    // The load step counts as part of the awake window
    assign on_phase    = (phase_q != PH_OFF);
    assign cycle_start = start_q;
    assign cycle_end   = end_q;

endmodule

// File: rtl/wkt_settle_timer.sv
// Module: wkt_settle_timer
// Measures the settling delay inside an awake window: SETTLE_US microsecond
// ticks, then RATE_PERIODS data-rate ticks, then a one-clock done strobe.
// Rate ticks only count once the microsecond stage has ended. The sequence
// is abandoned when the window closes or the block is disabled.
// Assumes: start arrives while on_phase is high.
module wkt_settle_timer
    import wkt_pkg::*;
#(
    parameter int SETTLE_US    = 2600,
    parameter int RATE_PERIODS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic on_phase,
    input  logic start,
    input  logic us_tick,
    input  logic rate_tick,
    output logic done
);

    localparam int US_W   = $clog2(SETTLE_US + 1);
    localparam int RATE_W = $clog2(RATE_PERIODS + 1);

    wkt_settle_e       st_q;
    logic [US_W-1:0]   us_cnt_q;
    logic [RATE_W-1:0] rate_cnt_q;
    logic              done_q;

    // Two-stage settling sequence with restart on every window start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            us_cnt_q   <= '0;
            rate_cnt_q <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!enable || !on_phase) begin
                st_q <= ST_IDLE;
            end else if (start) begin
                st_q     <= ST_US;
                us_cnt_q <= '0;
            end else begin
                case (st_q)
                    ST_US: begin
                        if (us_tick) begin
                            if (us_cnt_q == US_W'(SETTLE_US - 1)) begin
                                st_q       <= ST_RATE;
                                rate_cnt_q <= '0;
                            end else begin
                                us_cnt_q <= us_cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_RATE: begin
                        if (rate_tick) begin
                            if (rate_cnt_q == RATE_W'(RATE_PERIODS - 1)) begin
                                st_q   <= ST_IDLE;
                                done_q <= 1'b1;
                            end else begin
                                rate_cnt_q <= rate_cnt_q + 1'b1;
                            end
                        end
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign done = done_q;

endmodule

// File: rtl/wkt_pulse_gen.sv
// Module: wkt_pulse_gen
// Emits an active-low pulse of PULSE_US microsecond ticks for each request
// accepted while idle. A request that arrives during a pulse is dropped.
// Assumes: PULSE_US >= 1.
module wkt_pulse_gen #(
    parameter int PULSE_US = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic us_tick,
    output logic pulse_n
);

    localparam int CNT_W = $clog2(PULSE_US + 1);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;

    // Accept a request when idle; time the low level in microsecond ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (!active_q) begin
            cnt_q <= '0;
            if (req) begin
                active_q <= 1'b1;
            end
        end else if (us_tick) begin
            if (cnt_q == CNT_W'(PULSE_US - 1)) begin
                active_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign pulse_n = ~active_q;

endmodule

// File: rtl/wake_poll_timer.sv
// Module: wake_poll_timer (top)
// Wake-up scheduler. It combines the cycle timer, the settling sequencer and
// the pulse generator, picks the pulse source by mode, and gates the
// clock-output enable.
// Assumes: us_tick and rate_tick are single-clock strobes, and us_tick is
// never high on two consecutive clocks.
module wake_poll_timer
    import wkt_pkg::*;
#(
    parameter int TIME_W       = 16,
    parameter int PULSE_US     = 15,
    parameter int SETTLE_US    = 2600,
    parameter int RATE_PERIODS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              rate_tick,
    input  logic [1:0]        mode,
    input  logic              clk_always_on,
    input  logic [TIME_W-1:0] on_time,
    input  logic [TIME_W-1:0] off_time,
    input  logic              dv_strobe,
    output logic              irq_n,
    output logic              clkout_en,
    output logic              on_window
);

    wkt_mode_e mode_e;
    logic      on_phase;
    logic      cyc_start;
    logic      cyc_end;
    logic      settle_done;
    logic      pulse_req;
    logic      pulse_n;

    assign mode_e = wkt_mode_e'(mode);

    wkt_cycle_timer #(
        .TIME_W (TIME_W)
    ) cycle_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .us_tick     (us_tick),
        .on_time     (on_time),
        .off_time    (off_time),
        .on_phase    (on_phase),
        .cycle_start (cyc_start),
        .cycle_end   (cyc_end)
    );

    wkt_settle_timer #(
        .SETTLE_US    (SETTLE_US),
        .RATE_PERIODS (RATE_PERIODS)
    ) settle_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (mode_e == MODE_POLL),
        .on_phase  (on_phase),
        .start     (cyc_start),
        .us_tick   (us_tick),
        .rate_tick (rate_tick),
        .done      (settle_done)
    );

    // Pulse source selected by mode
    always_comb begin
        case (mode_e)
            MODE_TIMER: pulse_req = cyc_end;
            MODE_POLL:  pulse_req = settle_done;
            MODE_CONT:  pulse_req = dv_strobe;
            default:    pulse_req = 1'b0;
        endcase
    end

    wkt_pulse_gen #(
        .PULSE_US (PULSE_US)
    ) pulse_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (pulse_req),
        .us_tick (us_tick),
        .pulse_n (pulse_n)
    );

    // Clock-output enable: gated by the window only in polling mode
    always_comb begin
        if (clk_always_on || (mode_e != MODE_POLL)) begin
            clkout_en = 1'b1;
        end else begin
            clkout_en = on_phase && pulse_n;
        end
    end

    assign irq_n     = pulse_n;
    assign on_window = on_phase;

endmodule

// File: rtl/wake_poll_timer_chk.sv
// Module: wake_poll_timer_chk
// Port-level checker for wake_poll_timer, attached by bind below.
// Assumes: mode encodings from wkt_pkg.
module wake_poll_timer_chk
    import wkt_pkg::*;
#(
    parameter int PULSE_US = 15
) (
    input logic       clk,
    input logic       rst_n,
    input logic       us_tick,
    input logic [1:0] mode,
    input logic       clk_always_on,
    input logic       dv_strobe,
    input logic       irq_n,
    input logic       clkout_en,
    input logic       on_window
);

    logic [15:0] low_ticks_q;

    // Count microsecond ticks consumed while the interrupt line is low
    always_ff @(posedge clk) begin
        if (!rst_n || irq_n) begin
            low_ticks_q <= '0;
        end else if (us_tick && low_ticks_q != 16'hFFFF) begin
            low_ticks_q <= low_ticks_q + 1'b1;
        end
    end

    // R2, R7: a pulse ends after exactly PULSE_US ticks
    a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> (low_ticks_q == 16'(PULSE_US)));

    // R7: the low level never outlasts one pulse width
    a_r7_no_extend: assert property (@(posedge clk) disable iff (!rst_n)
        (low_ticks_q <= 16'(PULSE_US)));

    // R3: in timer mode a pulse starts right after the sleep window ends
    a_r3_timer_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(irq_n) && $past(mode, 2) == MODE_TIMER && $past(mode) == MODE_TIMER)
        |-> (!$past(on_window, 2) && $past(on_window)));

    // R4: a polling pulse is launched from inside the awake window
    a_r4_poll_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(irq_n) && $past(mode, 2) == MODE_POLL && $past(mode) == MODE_POLL)
        |-> $past(on_window, 2));

    // R6: a continuous-mode pulse follows a data-valid strobe
    a_r6_cont_follows_dv: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(irq_n) && $past(mode) == MODE_CONT) |-> $past(dv_strobe));

    // R8: gated clock is off during the sleep window and during a pulse
    a_r8_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_POLL && !clk_always_on && (!on_window || !irq_n))
        |-> !clkout_en);

    // R9: forced clock enable
    a_r9_forced_on: assert property (@(posedge clk) disable iff (!rst_n)
        clk_always_on |-> clkout_en);

endmodule

bind wake_poll_timer wake_poll_timer_chk #(
    .PULSE_US (PULSE_US)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .us_tick       (us_tick),
    .mode          (mode),
    .clk_always_on (clk_always_on),
    .dv_strobe     (dv_strobe),
    .irq_n         (irq_n),
    .clkout_en     (clkout_en),
    .on_window     (on_window)
);

// File: tb/wake_poll_timer_tb_top.sv
// Bench: directed tests, one task per scenario, each checking its own results.
module wake_poll_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int US_DIV     = 8;
    localparam int TW         = 16;
    localparam int WATCHDOG   = 190000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          us_tick = 1'b0;
    logic          rate_tick = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          clk_always_on = 1'b0;
    logic [TW-1:0] on_time = '0;
    logic [TW-1:0] off_time = '0;
    logic          dv_strobe = 1'b0;
    logic          irq_n;
    logic          clkout_en;
    logic          on_window;

    int checks = 0;
    int errors = 0;
    int us_count = 0;
    int div = 0;
    int base_us = 0;
    bit done_flag = 1'b0;

    wake_poll_timer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .us_tick       (us_tick),
        .rate_tick     (rate_tick),
        .mode          (mode),
        .clk_always_on (clk_always_on),
        .on_time       (on_time),
        .off_time      (off_time),
        .dv_strobe     (dv_strobe),
        .irq_n         (irq_n),
        .clkout_en     (clkout_en),
        .on_window     (on_window)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Microsecond strobe source; us_count counts strobes consumed by the DUT
    initial begin
        forever begin
            @(posedge clk);
            if (!rst_n) begin
                div     <= 0;
                us_tick <= 1'b0;
            end else begin
                if (us_tick) us_count <= us_count + 1;
                div     <= (div == US_DIV - 1) ? 0 : div + 1;
                us_tick <= (div == US_DIV - 1);
            end
        end
    end

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit sig(input int w);
        case (w)
            0:       return irq_n;
            1:       return on_window;
            default: return clkout_en;
        endcase
    endfunction

    // Wait for an edge of a selected output; returns us_count at detection
    task automatic wait_edge(input int w, input bit rising, input int max_clk,
                             output bit seen, output int at_us);
        bit prev = sig(w);
        seen  = 1'b0;
        at_us = 0;
        for (int i = 0; i < max_clk; i++) begin
            @(negedge clk);
            if (prev != sig(w) && sig(w) == rising) begin
                seen  = 1'b1;
                at_us = us_count;
                break;
            end
            prev = sig(w);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n   = 1'b1;
        base_us = us_count;
    endtask

    task automatic rate_pulse();
        @(negedge clk);
        rate_tick = 1'b1;
        @(negedge clk);
        rate_tick = 1'b0;
    endtask

    task automatic strobe_dv();
        @(negedge clk);
        dv_strobe = 1'b1;
        @(negedge clk);
        dv_strobe = 1'b0;
    endtask

    // Reset state
    task automatic test_reset();
        mode = 2'd1; clk_always_on = 1'b0; on_time = 16'd50; off_time = 16'd50;
        do_reset();
        check(irq_n == 1'b1, "R1 irq_n after reset", irq_n, 1);
        check(on_window == 1'b1, "R1 on_window after reset", on_window, 1);
        check(clkout_en == 1'b1, "R1 clkout_en after reset", clkout_en, 1);
    endtask

    // Timer mode: window lengths, cycle spacing, length update timing
    task automatic test_timer();
        bit seen; int t0; int t1;
        mode = 2'd0; clk_always_on = 1'b0; on_time = 16'd20; off_time = 16'd30;
        do_reset();
        wait_edge(1, 1'b0, 400, seen, t0);
        check(seen && (t0 - base_us) == 20, "R3 awake window length", t0 - base_us, 20);
        wait_edge(0, 1'b0, 400, seen, t1);
        check(seen && (t1 - base_us) == 50, "R3 first cycle fall", t1 - base_us, 50);
        check(clkout_en == 1'b1, "R9 clock on during pulse in timer mode", clkout_en, 1);
        on_time = 16'd40;
        wait_edge(0, 1'b0, 800, seen, t0);
        check(seen && (t0 - t1) == 50, "R10 cycle in progress keeps old length", t0 - t1, 50);
        wait_edge(0, 1'b0, 1000, seen, t1);
        check(seen && (t1 - t0) == 70, "R10 next cycle uses new length", t1 - t0, 70);
    endtask

    // Polling mode with free-running rate strobe: delay, width, gating
    task automatic test_poll_delay();
        bit seen; int t0; int t1;
        mode = 2'd1; clk_always_on = 1'b0; on_time = 16'd3000; off_time = 16'd50;
        rate_tick = 1'b1;
        do_reset();
        wait_edge(0, 1'b0, 3000 * US_DIV, seen, t0);
        check(seen && (t0 - base_us) == 2600, "R4 settle delay to pulse", t0 - base_us, 2600);
        check(clkout_en == 1'b0, "R8 clock off during pulse", clkout_en, 0);
        wait_edge(0, 1'b1, 400, seen, t1);
        check(seen && (t1 - t0) == 15, "R2 pulse width in polling mode", t1 - t0, 15);
        check(clkout_en == 1'b1, "R8 clock on in window after pulse", clkout_en, 1);
        wait_edge(1, 1'b0, 3000 * US_DIV, seen, t1);
        check(seen && clkout_en == 1'b0, "R8 clock off in sleep window", clkout_en, 0);
        rate_tick = 1'b0;
    endtask

    // Polling mode: early rate strobes ignored, exactly three needed afterwards
    task automatic test_poll_rate_order();
        bit fell = 1'b0;
        mode = 2'd1; clk_always_on = 1'b0; on_time = 16'd3000; off_time = 16'd50;
        rate_tick = 1'b0;
        do_reset();
        repeat (100 * US_DIV) @(negedge clk);
        rate_pulse(); rate_pulse(); rate_pulse();
        while (us_count - base_us < 2700) begin
            @(negedge clk);
            if (!irq_n) fell = 1'b1;
        end
        check(!fell, "R4 early rate strobes not counted", fell, 0);
        rate_pulse(); rate_pulse();
        repeat (10) @(negedge clk);
        check(irq_n == 1'b1, "R4 two rate strobes not enough", irq_n, 1);
        rate_pulse();
        @(negedge clk);
        check(irq_n == 1'b0, "R4 pulse after third rate strobe", irq_n, 0);
    endtask

    // Polling mode with a window shorter than the settling delay
    task automatic test_poll_short();
        bit fell = 1'b0; int win_falls = 0; bit prev_w;
        mode = 2'd1; clk_always_on = 1'b0; on_time = 16'd100; off_time = 16'd100;
        rate_tick = 1'b1;
        do_reset();
        prev_w = on_window;
        for (int i = 0; i < 600 * US_DIV; i++) begin
            @(negedge clk);
            if (!irq_n) fell = 1'b1;
            if (prev_w && !on_window) win_falls++;
            prev_w = on_window;
        end
        check(!fell, "R5 no pulse in short window", fell, 0);
        check(win_falls >= 2, "R5 windows keep cycling", win_falls, 3);
        rate_tick = 1'b0;
    endtask

    // Forced clock enable in polling mode
    task automatic test_clk_forced();
        bit low = 1'b0;
        mode = 2'd1; clk_always_on = 1'b1; on_time = 16'd10; off_time = 16'd10;
        do_reset();
        for (int i = 0; i < 50 * US_DIV; i++) begin
            @(negedge clk);
            if (!clkout_en) low = 1'b1;
        end
        check(!low, "R9 forced clock enable stays high", low, 0);
        clk_always_on = 1'b0;
    endtask

    // Continuous mode, retrigger suppression, strobe ignored elsewhere
    task automatic test_continuous();
        bit seen; int t0; int t1; bit fell = 1'b0;
        mode = 2'd2; clk_always_on = 1'b0; on_time = 16'd1000; off_time = 16'd1000;
        do_reset();
        repeat (5) @(negedge clk);
        strobe_dv();
        check(irq_n == 1'b0, "R6 pulse starts on strobe edge", irq_n, 0);
        t0 = us_count;
        repeat (3 * US_DIV) @(negedge clk);
        strobe_dv();
        wait_edge(0, 1'b1, 400, seen, t1);
        check(seen && (t1 - t0) == 15, "R7 strobe during pulse ignored", t1 - t0, 15);
        repeat (3) @(negedge clk);
        strobe_dv();
        check(irq_n == 1'b0, "R6 next strobe gives new pulse", irq_n, 0);
        wait_edge(0, 1'b1, 400, seen, t1);
        mode = 2'd0;
        repeat (3) @(negedge clk);
        strobe_dv();
        repeat (20) @(negedge clk);
        check(irq_n == 1'b1, "R6 strobe ignored in timer mode", irq_n, 1);
        mode = 2'd3; on_time = 16'd10; off_time = 16'd10;
        do_reset();
        for (int i = 0; i < 60 * US_DIV; i++) begin
            @(negedge clk);
            if (!irq_n) fell = 1'b1;
        end
        check(!fell, "R6 silent mode issues no pulse", fell, 0);
    endtask

    initial begin
        test_reset();
        test_timer();
        test_poll_delay();
        test_poll_rate_order();
        test_poll_short();
        test_clk_forced();
        test_continuous();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: an expired run counts as one failed check
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule